// File: doc/BRIEF.md
# Masked Packed Variable Right Shifter

This unit takes a packed vector of unsigned elements and moves each element toward its least significant end by an amount read from the element at the same position in a count vector. Zeros enter from the top of every element. The element size can be 16, 32 or 64 bits. The active part of the 512-bit datapath can be 128, 256 or 512 bits wide. Bits above the active part always come out as zero.

Each lane can be gated by a write mask. A lane that the mask leaves inactive either keeps the matching lane of an old destination vector or is cleared, depending on the selected mode. For 32- and 64-bit elements, a broadcast option lets every lane use the lowest count element. A legacy mode ignores the mask and the broadcast option and accepts only the narrower lengths with the wider elements.

The result is registered. It appears one clock after the input strobe, together with an output valid flag.

Top module: `vshr_unit`

## Requirements
- R1: Element width code `elem_w` selects the lane size: 2'b00 = 16 bits, 2'b01 = 32 bits, 2'b10 = 64 bits. Each computed lane equals its `src_a` element shifted right logically, with the vacated high bits set to 0.
- R2: The count of a lane is the complete unsigned element of `src_cnt` at that lane's position. Any count greater than or equal to the lane width gives a lane result of 0, even when the low count bits are small.
- R3: Length code `vec_len` selects the active length: 2'b00 = 128, 2'b01 = 256, 2'b10 = 512 bits. The active length divided by the element width gives the number of lanes.
- R4: With `mask_en` = 1 and `zero_fill` = 0, a lane whose bit in `wr_mask` is 0 returns the matching lane of `dst_old` unchanged.
- R5: With `mask_en` = 1 and `zero_fill` = 1, a lane whose bit in `wr_mask` is 0 returns 0.
- R6: With `mask_en` = 0, every lane inside the active length is computed, whatever `wr_mask` holds.
- R7: With `bcast` = 1 and 32- or 64-bit elements, every lane uses the lowest element of `src_cnt` as its count.
- R8: With 16-bit elements, `bcast` has no effect and every lane uses its own count.
- R9: All result bits from the active length up to bit 511 are 0, in every mask and merge mode.
- R10: With `legacy` = 1, `wr_mask`, `mask_en` and `bcast` are ignored and every active lane is computed. Only 128 or 256 bits with 32- or 64-bit elements are accepted. A 16-bit element width or a 512-bit length in this mode gives an all-zero result.
- R11: An element width code of 2'b11 or a length code of 2'b11 gives an all-zero result.
- R12: `result` and `out_valid` change on the clock edge after `in_valid` is high. `out_valid` is high for exactly the one cycle following each strobe. `result` holds its value while `in_valid` is low.
- R13: A synchronous active-high `rst` clears `result` and `out_valid`.
- R14: Only the low (active length / element width) bits of `wr_mask` take part. Higher mask bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | Elements to be shifted |
| src_cnt | input | 512 | Per-lane shift counts |
| dst_old | input | 512 | Prior destination, used for merging |
| wr_mask | input | 64 | Per-lane write mask |
| elem_w | input | 2 | Element width code |
| vec_len | input | 2 | Active length code |
| mask_en | input | 1 | Enables masking |
| zero_fill | input | 1 | Inactive lanes cleared (1) or merged (0) |
| bcast | input | 1 | Use the lowest count element for all lanes |
| legacy | input | 1 | Unmasked legacy operation |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 512 | Registered result vector |

## Verification
Two situations are hard to bring about from the ports.

The first is an over-range count whose low bits still look like a small legal shift, such as a 64-bit count of 2^32+1. Uniformly random counts almost never produce small values, so the stimulus draws most counts below the lane width, some just at or above it, and some with random upper bits. Directed cases also place values with high bits set and low bits near zero.

The second is telling merged lanes apart from zeroed ones. This needs a non-zero old destination under a sparse mask. The random stimulus always fills `dst_old` with random data and mixes every mode, so a lane that is wrongly cleared or wrongly kept shows up as a mismatch.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
  typedef enum logic [1:0] {EW16 = 2'b00, EW32 = 2'b01, EW64 = 2'b10, EW_BAD = 2'b11} ew_t;
  typedef enum logic [1:0] {VL128 = 2'b00, VL256 = 2'b01, VL512 = 2'b10, VL_BAD = 2'b11} vl_t;
  typedef enum logic [1:0] {SEL_ZERO = 2'b00, SEL_CALC = 2'b01, SEL_KEEP = 2'b10} gsel_t;
  localparam int GRAN_W = 16;
endpackage

// File: rtl/vshr_shift_bank.sv
module vshr_shift_bank #(
  parameter int DATA_W = 512,
  parameter int EW     = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] cnt,
  input  logic              bcast,
  output logic [DATA_W-1:0] res
);
  localparam int NL = DATA_W / EW;
  localparam int CW = $clog2(EW);

  for (genvar j = 0; j < NL; j++) begin : g_lane
    logic [EW-1:0] elem;
    logic [EW-1:0] c;
    logic          over;
    assign elem = src[j*EW +: EW];
    assign c    = bcast ? cnt[EW-1:0] : cnt[j*EW +: EW];
    assign over = |c[EW-1:CW];
    assign res[j*EW +: EW] = over ? '0 : (elem >> c[CW-1:0]);
  end
endmodule

// File: rtl/vshr_lane_policy.sv
module vshr_lane_policy
  import vshr_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int MASK_W = 64
) (
  input  ew_t          ew,
  input  vl_t          vl,
  input  logic [MASK_W-1:0] mask,
  input  logic         mask_en,
  input  logic         zero_fill,
  input  logic         legacy,
  output gsel_t        sel [DATA_W/GRAN_W]
);
  localparam int NG     = DATA_W / GRAN_W;
  localparam int NG_MIN = NG / 4;
  localparam int GW     = $clog2(NG) + 1;
  localparam int LW     = $clog2(NG);

  logic          bad;
  logic [GW-1:0] ng_act;

  always_comb begin
    bad    = (ew == EW_BAD) || (vl == VL_BAD) || (legacy && (ew == EW16 || vl == VL512));
    ng_act = GW'(NG_MIN) << vl;
  end

  for (genvar g = 0; g < NG; g++) begin : g_gran
    logic [LW-1:0] lane;
    logic          on;
    always_comb begin
      lane = LW'(g) >> ew;
      on   = legacy || !mask_en || mask[lane];
      if (bad || GW'(g) >= ng_act) sel[g] = SEL_ZERO;
      else if (on)                 sel[g] = SEL_CALC;
      else if (zero_fill)          sel[g] = SEL_ZERO;
      else                         sel[g] = SEL_KEEP;
    end

    // R4
    always_comb begin
      if (sel[g] == SEL_KEEP) begin
        keep_mode_chk: assert (mask_en && !zero_fill && !legacy);
      end
    end
  end
endmodule

// File: rtl/vshr_unit.sv
module vshr_unit
  import vshr_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_cnt,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [1:0]        elem_w,
  input  logic [1:0]        vec_len,
  input  logic              mask_en,
  input  logic              zero_fill,
  input  logic              bcast,
  input  logic              legacy,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NG    = DATA_W / GRAN_W;
  localparam int VL_MIN = DATA_W / 4;

  ew_t ew;
  vl_t vl;
  logic bcast_eff;
  logic [DATA_W-1:0] r16, r32, r64, nxt;
  gsel_t sel [NG];

  assign ew        = ew_t'(elem_w);
  assign vl        = vl_t'(vec_len);
  assign bcast_eff = bcast && !legacy;

  vshr_shift_bank #(.DATA_W(DATA_W), .EW(16)) i_bank16 (
    .src(src_a), .cnt(src_cnt), .bcast(1'b0), .res(r16));
  vshr_shift_bank #(.DATA_W(DATA_W), .EW(32)) i_bank32 (
    .src(src_a), .cnt(src_cnt), .bcast(bcast_eff), .res(r32));
  vshr_shift_bank #(.DATA_W(DATA_W), .EW(64)) i_bank64 (
    .src(src_a), .cnt(src_cnt), .bcast(bcast_eff), .res(r64));

  vshr_lane_policy #(.DATA_W(DATA_W), .MASK_W(MASK_W)) i_policy (
    .ew(ew), .vl(vl), .mask(wr_mask), .mask_en(mask_en),
    .zero_fill(zero_fill), .legacy(legacy), .sel(sel));

  for (genvar g = 0; g < NG; g++) begin : g_mux
    logic [GRAN_W-1:0] calc;
    always_comb begin
      case (ew)
        EW16:    calc = r16[g*GRAN_W +: GRAN_W];
        EW32:    calc = r32[g*GRAN_W +: GRAN_W];
        default: calc = r64[g*GRAN_W +: GRAN_W];
      endcase
      case (sel[g])
        SEL_CALC: nxt[g*GRAN_W +: GRAN_W] = calc;
        SEL_KEEP: nxt[g*GRAN_W +: GRAN_W] = dst_old[g*GRAN_W +: GRAN_W];
        default:  nxt[g*GRAN_W +: GRAN_W] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R12
  vld_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vec_len == 2'b00) |=> (result[DATA_W-1:VL_MIN] == '0));

  // R11
  bad_enc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (elem_w == 2'b11 || vec_len == 2'b11)) |=> (result == '0));

  // R10
  legacy_w16_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy && elem_w == 2'b00) |=> (result == '0));
endmodule

// File: tb/test_vshr_unit.sv
module test_vshr_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [511:0] src_a, src_cnt, dst_old;
  logic [63:0]  wr_mask;
  logic [1:0]   elem_w, vec_len;
  logic         mask_en, zero_fill, bcast, legacy;
  logic         out_valid;
  logic [511:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vshr_unit i_vshr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_cnt(src_cnt),
    .dst_old(dst_old), .wr_mask(wr_mask), .elem_w(elem_w), .vec_len(vec_len),
    .mask_en(mask_en), .zero_fill(zero_fill), .bcast(bcast), .legacy(legacy),
    .out_valid(out_valid), .result(result));

  function automatic logic [511:0] model(
    logic [511:0] a, logic [511:0] b, logic [511:0] old, logic [63:0] m,
    logic [1:0] ew, logic [1:0] vl, logic men, logic zf, logic bc, logic leg);
    int w, v, bidx;
    logic [63:0] msk, ae, ce, oe, le;
    logic [511:0] r;
    r = '0;
    w = (ew == 2'b00) ? 16 : (ew == 2'b01) ? 32 : (ew == 2'b10) ? 64 : 0;
    v = (vl == 2'b00) ? 128 : (vl == 2'b01) ? 256 : (vl == 2'b10) ? 512 : 0;
    if (w == 0 || v == 0 || (leg && (w == 16 || v == 512))) return '0;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int j = 0; j < v / w; j++) begin
      bidx = (bc && !leg && w != 16) ? 0 : j;
      ae = 64'(a >> (j * w)) & msk;
      ce = 64'(b >> (bidx * w)) & msk;
      oe = 64'(old >> (j * w)) & msk;
      if (leg || !men || m[j]) le = (ce >= 64'(w)) ? 64'd0 : (ae >> ce);
      else if (zf)             le = 64'd0;
      else                     le = oe;
      r = r | (512'(le) << (j * w));
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] x;
    for (int k = 0; k < 16; k++) x[k*32 +: 32] = $urandom;
    return x;
  endfunction

  function automatic logic [511:0] rnd_counts(logic [1:0] ew);
    int w, r;
    logic [63:0] c, msk;
    logic [511:0] x;
    x = '0;
    w = (ew == 2'b00) ? 16 : (ew == 2'b01) ? 32 : 64;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int j = 0; j < 512 / w; j++) begin
      r = $urandom % 10;
      if (r < 7)      c = 64'($urandom % w);
      else if (r < 8) c = 64'(w + ($urandom % 4));
      else            c = {$urandom, $urandom};
      x = x | (512'(c & msk) << (j * w));
    end
    return x;
  endfunction

  task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [511:0] a, logic [511:0] b, logic [511:0] old,
                        logic [63:0] m, logic [1:0] ew, logic [1:0] vl,
                        logic men, logic zf, logic bc, logic leg);
    logic [511:0] exp;
    exp = model(a, b, old, m, ew, vl, men, zf, bc, leg);
    @(negedge clk);
    src_a = a; src_cnt = b; dst_old = old; wr_mask = m; elem_w = ew; vec_len = vl;
    mask_en = men; zero_fill = zf; bcast = bc; legacy = leg; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R12 valid"}, {511'd0, out_valid}, 512'd1);
    check(tag, result, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] ones, held;
    void'($urandom(32'd4242));
    ones = '1;
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_cnt = '0; dst_old = '0; wr_mask = '0;
    elem_w = 2'b00; vec_len = 2'b00; mask_en = 1'b0; zero_fill = 1'b0; bcast = 1'b0; legacy = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 reset result", result, '0);
    check("R13 reset valid", {511'd0, out_valid}, '0);
    rst = 1'b0;

    // R1: increasing counts, 32-bit, full length
    begin
      logic [511:0] c;
      c = '0;
      for (int j = 0; j < 16; j++) c[j*32 +: 32] = 32'(j);
      run_op("R1 w32 ramp", ones, c, '0, '0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R2: counts at width and with high bits set but small low bits
    begin
      logic [511:0] c;
      c = '0;
      c[63:0] = 64'd64; c[127:64] = 64'd63; c[191:128] = 64'h1_0000_0001; c[255:192] = 64'h8000_0000_0000_0000;
      run_op("R2 w64 over", ones, c, '0, '0, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
      c = '0;
      for (int j = 0; j < 32; j++) c[j*16 +: 16] = (j % 2 == 0) ? 16'd16 : 16'h0101;
      run_op("R2 w16 over", ones, c, '0, '0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R4 R5 R6 masking modes
    run_op("R4 merge", rnd512(), rnd_counts(2'b01), rnd512(), 64'h5555, 2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op("R5 zero",  rnd512(), rnd_counts(2'b01), rnd512(), 64'h5555, 2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op("R6 nomask", rnd512(), rnd_counts(2'b00), rnd512(), 64'h0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7 R8 broadcast
    run_op("R7 bcast w64", rnd512(), rnd_counts(2'b10), rnd512(), '1, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op("R7 bcast w32", rnd512(), rnd_counts(2'b01), rnd512(), '1, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
    run_op("R8 bcast w16", rnd512(), rnd_counts(2'b00), rnd512(), '1, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
    // R3 R9 length and upper zeroing under merge with old all ones
    run_op("R9 vl128 merge", rnd512(), rnd_counts(2'b01), ones, 64'h0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op("R3 vl256 w16", rnd512(), rnd_counts(2'b00), ones, 64'hFFFF_0F0F, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10 legacy
    run_op("R10 legacy ok", rnd512(), rnd_counts(2'b10), ones, 64'h0, 2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op("R10 legacy w16", rnd512(), rnd_counts(2'b00), ones, '1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    run_op("R10 legacy vl512", rnd512(), rnd_counts(2'b01), ones, '1, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
    // R11 bad encodings
    run_op("R11 bad ew", rnd512(), rnd_counts(2'b01), ones, '1, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R11 bad vl", rnd512(), rnd_counts(2'b01), ones, '1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    // R14 upper mask bits ignored
    run_op("R14 mask hi", rnd512(), rnd_counts(2'b10), ones, 64'hFFFF_FFFF_FFFF_FFFC, 2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);

    // R12 hold while idle
    held = result;
    @(negedge clk);
    src_a = rnd512(); src_cnt = '0;
    @(negedge clk);
    check("R12 hold", result, held);
    check("R12 valid low", {511'd0, out_valid}, '0);

    // random mix (R3 sweep)
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ew, vl;
      ew = 2'($urandom % 4);
      vl = 2'($urandom % 4);
      run_op("R3 random", rnd512(), rnd_counts(ew == 2'b11 ? 2'b01 : ew), rnd512(),
             {$urandom, $urandom}, ew, vl, 1'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 5) == 0);
    end

    // R13 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R13 rerun result", result, '0);
    check("R13 rerun valid", {511'd0, out_valid}, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule